// File: doc/BRIEF.md
# Regulator Supervisor and Sleep Controller

This block sits beside a linear regulator and decides two things every clock: whether the regulated output may be driven, and whether the system reset is held. It sees an enable pin, a sampled code of the output voltage, overvoltage and overtemperature flags, and the fault flag of a separate watchdog window monitor. All of them arrive as synchronous signals. It drives an output-enable, an active-low reset and a sleep indicator.

The output is switched off only when two conditions meet: the enable pin is low and the watchdog is out of its window. A processor that keeps its enable line low can therefore finish its own shutdown work and then power itself down by stopping its watchdog pulses. Raising the enable pin again wakes the block into a fresh power-up. Power-up holds reset for a programmable delay once the output is in regulation. An undervoltage that lasts long enough drops reset and restarts that delay. Overvoltage or overtemperature cuts the output at once. All pins are plain control and status levels. There is no data stream and no handshake.

The output-voltage code is compared against two thresholds with hysteresis. A dip below the lower threshold only counts after a programmable number of consecutive cycles below it. Regulation is restored only when the code reaches the upper threshold.

Top module: `rail_supervisor`

## Requirements
- R1: While the enable pin is high and neither protection flag is set, `out_en` is 1 one cycle later, whatever the state of `wd_fault`.
- R2: While the output is enabled, no protection flag is set, `en_pin` is 0 and `wd_fault` is 1, the next clock enters sleep: `sleep_o`=1, `out_en`=0, `rst_out_n`=0. With `en_pin` 0 and `wd_fault` 0, the output stays on and reset stays released.
- R3: From sleep, the first clock with `en_pin`=1 leaves sleep and restarts power-up. With the code at or above `HI_CODE` and `wd_fault` 0, `rst_out_n` rises on the POR_CYC+2-th rising edge after `en_pin` goes high.
- R4: After `rst_n` is released, with the code at or above `HI_CODE` and `wd_fault`=0, `rst_out_n` rises on exactly the POR_CYC+2-th rising edge. If `wd_fault` is 1 when the delay is done, reset stays low, and it rises one edge after `wd_fault` returns to 0.
- R5: A run of fewer than QUAL_CYC consecutive cycles with the code below `LO_CODE` has no effect on `rst_out_n`.
- R6: A run of QUAL_CYC or more consecutive cycles below `LO_CODE` drops `rst_out_n` and clears the delay. After the code returns to `HI_CODE` or above, `rst_out_n` rises on the POR_CYC+2-th edge.
- R7: Codes from `LO_CODE` to `HI_CODE`-1 inclusive keep the regulation status as it is: they never qualify an undervoltage, and they never restore regulation.
- R8: If `ov_flag` or `ot_flag` is 1, then one edge later `out_en`=0 and `rst_out_n`=0, regardless of the enable pin or the watchdog. Once both flags clear, power-up restarts and `rst_out_n` rises POR_CYC+2 edges later.
- R9: After power-up has completed, with `en_pin`=1, a `wd_fault` of 1 drops `rst_out_n` one edge later while `out_en` stays 1. Reset rises one edge after the fault clears.
- R10: While `rst_n` is 0: `out_en`=1, `rst_out_n`=0, `sleep_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| en_pin | input | 1 | Enable request, high keeps the output on |
| vout_code | input | CODE_W | Unsigned sampled output-voltage code |
| ov_flag | input | 1 | Input overvoltage detected |
| ot_flag | input | 1 | Overtemperature detected |
| wd_fault | input | 1 | Watchdog is out of its window |
| out_en | output | 1 | Drive the regulated output |
| rst_out_n | output | 1 | Active-low system reset |
| sleep_o | output | 1 | Block is in low-power sleep |

## Verification
The bench builds the block with POR_CYC=20, QUAL_CYC=4, LO_CODE=188 and HI_CODE=196. The short delay lets every power-up, wake and recovery path be timed to the exact edge many times in one run. The small qualification count makes it possible to sweep dip lengths from 1 to QUAL_CYC+1 cycles, covering both sides of the filter boundary. The narrow hysteresis band is walked code by code, in both the regulated and unregulated state. All four enable/watchdog combinations are applied from the running state.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    SUP_PWRUP = 2'd0,
    SUP_RUN   = 2'd1,
    SUP_SLEEP = 2'd2,
    SUP_PROT  = 2'd3
  } sup_state_t;

  function automatic logic drives_output(sup_state_t s);
    return (s == SUP_PWRUP) || (s == SUP_RUN);
  endfunction
endpackage

// File: rtl/sup_uv_filter.sv
module sup_uv_filter #(
  parameter int CODE_W   = 8,
  parameter int LO_CODE  = 188,
  parameter int HI_CODE  = 196,
  parameter int QUAL_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vout_code,
  output logic              in_reg
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [QW-1:0] qcnt;
  logic          below;
  logic          above;

  assign below = vout_code < CODE_W'(LO_CODE);
  assign above = vout_code >= CODE_W'(HI_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt   <= '0;
      in_reg <= 1'b0;
    end else begin
      if (!below)
        qcnt <= '0;
      else if (qcnt != QW'(QUAL_CYC))
        qcnt <= qcnt + QW'(1);
      if (above)
        in_reg <= 1'b1;
      else if (below && qcnt == QW'(QUAL_CYC - 1))
        in_reg <= 1'b0;
    end
  end

  // R5 / R7: no loss of regulation unless the code sat below the low threshold
  a_r5_no_drop_above_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !below |=> !$fell(in_reg));
  // R7: regulation is only regained at or above the high threshold
  a_r7_rise_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_reg) |-> $past(above));
endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer #(
  parameter int POR_CYC = 4750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(POR_CYC + 1);

  logic [TW-1:0] tcnt;

  assign done = (tcnt == TW'(POR_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tcnt <= '0;
    else if (!run)
      tcnt <= '0;
    else if (!done)
      tcnt <= tcnt + TW'(1);
  end

  // R6: a stop of the run condition clears the elapsed delay
  a_r6_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/sup_state_ctl.sv
module sup_state_ctl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       wd_fault,
  input  logic       prot,
  input  logic       in_reg,
  input  logic       por_done,
  output sup_state_t state,
  output logic       rst_q
);
  sup_state_t nxt;
  logic       go_sleep;

  assign go_sleep = !en_pin && wd_fault;

  always_comb begin
    nxt = state;
    if (prot)
      nxt = SUP_PROT;
    else begin
      case (state)
        SUP_PROT:  nxt = SUP_PWRUP;
        SUP_SLEEP: if (en_pin) nxt = SUP_PWRUP;
        SUP_PWRUP: begin
          if (go_sleep)                           nxt = SUP_SLEEP;
          else if (por_done && in_reg && !wd_fault) nxt = SUP_RUN;
        end
        SUP_RUN: begin
          if (go_sleep)     nxt = SUP_SLEEP;
          else if (!in_reg) nxt = SUP_PWRUP;
        end
        default: nxt = SUP_PWRUP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SUP_PWRUP;
      rst_q <= 1'b0;
    end else begin
      state <= nxt;
      rst_q <= (nxt == SUP_RUN) && !wd_fault;
    end
  end

  // R3: an enable request always leaves sleep
  a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_SLEEP && en_pin && !prot) |=> state == SUP_PWRUP);
  // R4: reset release needs an elapsed delay, regulation and a good watchdog
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(por_done) && $past(in_reg) && !$past(wd_fault)));
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import sup_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int LO_CODE  = 188,
  parameter int HI_CODE  = 196,
  parameter int QUAL_CYC = 200,
  parameter int POR_CYC  = 4750000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic [CODE_W-1:0] vout_code,
  input  logic              ov_flag,
  input  logic              ot_flag,
  input  logic              wd_fault,
  output logic              out_en,
  output logic              rst_out_n,
  output logic              sleep_o
);
  sup_state_t state;
  logic       in_reg;
  logic       por_done;
  logic       prot;
  logic       rst_q;

  assign prot      = ov_flag || ot_flag;
  assign out_en    = drives_output(state);
  assign sleep_o   = (state == SUP_SLEEP);
  assign rst_out_n = rst_q;

  sup_uv_filter #(
    .CODE_W(CODE_W), .LO_CODE(LO_CODE), .HI_CODE(HI_CODE), .QUAL_CYC(QUAL_CYC)
  ) u_uv (
    .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .in_reg(in_reg)
  );

  sup_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .run(out_en && in_reg), .done(por_done)
  );

  sup_state_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .wd_fault(wd_fault),
    .prot(prot), .in_reg(in_reg), .por_done(por_done),
    .state(state), .rst_q(rst_q)
  );

  // R1: enable high keeps the output on
  a_r1_enable_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && !prot) |=> out_en);
  // R2: enable low plus watchdog fault enters sleep
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !en_pin && wd_fault && !prot) |=> (sleep_o && !out_en));
  // R8: protection cuts output and asserts reset
  a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> (!out_en && !rst_out_n));
  // R10: reset values
  a_r10_reset_vals: assert property (@(posedge clk)
    !rst_n |-> (out_en && !rst_out_n && !sleep_o));
endmodule

// File: tb/sim_rail_supervisor.sv
`timescale 1ns/1ps
module sim_rail_supervisor;
  localparam int W   = 8;
  localparam int LO  = 188;
  localparam int HI  = 196;
  localparam int QL  = 4;
  localparam int POR = 20;
  localparam int GOOD = 200;
  localparam int DIP  = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b1;
  logic [W-1:0] vout_code = W'(GOOD);
  logic ov_flag = 1'b0, ot_flag = 1'b0, wd_fault = 1'b0;
  logic out_en, rst_out_n, sleep_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rail_supervisor #(
    .CODE_W(W), .LO_CODE(LO), .HI_CODE(HI), .QUAL_CYC(QL), .POR_CYC(POR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .vout_code(vout_code),
    .ov_flag(ov_flag), .ot_flag(ot_flag), .wd_fault(wd_fault),
    .out_en(out_en), .rst_out_n(rst_out_n), .sleep_o(sleep_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // edges until reset is released
  task automatic measure(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!rst_out_n && n < 500);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic seen_low;
    logic seen_high;

    // R10 reset values
    step();
    chk("R10 out_en in reset", int'(out_en), 1);
    chk("R10 rst_out_n in reset", int'(rst_out_n), 0);
    chk("R10 sleep_o in reset", int'(sleep_o), 0);

    // R4 power-up delay
    do_reset();
    measure(n);
    chk("R4 power-up release edge", n, POR + 2);

    // R4 watchdog holds reset after the delay
    wd_fault = 1'b1;
    do_reset();
    seen_high = 1'b0;
    for (int i = 0; i < POR + 10; i++) begin
      step();
      if (rst_out_n) seen_high = 1'b1;
    end
    chk("R4 reset held while watchdog faulty", int'(seen_high), 0);
    wd_fault = 1'b0;
    step();
    chk("R4 release one edge after watchdog good", int'(rst_out_n), 1);

    // R9 watchdog fault while running, enable high
    wd_fault = 1'b1;
    step();
    chk("R9 reset drops on fault", int'(rst_out_n), 0);
    chk("R9 output stays on", int'(out_en), 1);
    wd_fault = 1'b0;
    step();
    chk("R9 reset back after fault", int'(rst_out_n), 1);

    // R1 / R2 / R3 enable x watchdog table from the running state
    for (int e = 0; e < 2; e++) begin
      for (int w = 0; w < 2; w++) begin
        en_pin = e[0];
        wd_fault = w[0];
        step();
        step();
        chk((e == 1) ? "R1 out_en table" : "R2 out_en table", int'(out_en), (e == 1 || w == 0) ? 1 : 0);
        chk("R2 sleep_o table", int'(sleep_o), (e == 0 && w == 1) ? 1 : 0);
        chk("R9 rst_out_n table", int'(rst_out_n), (w == 0) ? 1 : 0);
        if (e == 0 && w == 1) begin
          vout_code = W'(0);
          for (int i = 0; i < QL + 3; i++) step();
          chk("R2 still asleep with enable low", int'(sleep_o), 1);
          vout_code = W'(GOOD);
          en_pin = 1'b1;
          wd_fault = 1'b0;
          measure(n);
          chk("R3 wake restarts full delay", n, POR + 2);
          chk("R3 output on after wake", int'(out_en), 1);
        end else begin
          en_pin = 1'b1;
          wd_fault = 1'b0;
          step();
          chk("R1 running after table entry", int'(rst_out_n), 1);
        end
      end
    end

    // R5 / R6 dip length sweep
    for (int len = 1; len <= QL + 1; len++) begin
      seen_low = 1'b0;
      vout_code = W'(DIP);
      for (int i = 0; i < len; i++) begin
        step();
        if (!rst_out_n) seen_low = 1'b1;
      end
      vout_code = W'(GOOD);
      measure(n);
      if (len < QL) begin
        chk("R5 short dip ignored (during)", int'(seen_low), 0);
        chk("R5 short dip ignored (after)", n, 1);
      end else begin
        chk("R6 qualified dip restarts delay", n, POR + 2);
      end
    end

    // R7 band codes while regulated
    for (int c = LO; c < HI; c++) begin
      vout_code = W'(c);
      seen_low = 1'b0;
      for (int i = 0; i < QL + 2; i++) begin
        step();
        if (!rst_out_n) seen_low = 1'b1;
      end
      chk("R7 band code keeps regulation", int'(seen_low), 0);
    end

    // R6 then R7 band codes while unregulated
    vout_code = W'(DIP);
    for (int i = 0; i < QL + 1; i++) step();
    chk("R6 reset low after qualified dip", int'(rst_out_n), 0);
    seen_high = 1'b0;
    for (int c = DIP; c < HI; c++) begin
      vout_code = W'(c);
      step();
      if (rst_out_n) seen_high = 1'b1;
    end
    chk("R7 band code does not restore", int'(seen_high), 0);
    vout_code = W'(HI);
    measure(n);
    chk("R7 high threshold restores", n, POR + 2);

    // R8 protection, each flag, with enable high
    for (int f = 0; f < 2; f++) begin
      if (f == 0) ov_flag = 1'b1; else ot_flag = 1'b1;
      step();
      chk("R8 protection output off", int'(out_en), 0);
      chk("R8 protection reset low", int'(rst_out_n), 0);
      for (int i = 0; i < 5; i++) step();
      chk("R8 protection held", int'(out_en), 0);
      ov_flag = 1'b0;
      ot_flag = 1'b0;
      measure(n);
      chk("R8 recovery delay", n, POR + 2);
      chk("R8 output on after recovery", int'(out_en), 1);
    end

    // R8 protection overrides sleep-exit enable too
    en_pin = 1'b0;
    wd_fault = 1'b1;
    ov_flag = 1'b1;
    step();
    chk("R8 protection wins over sleep", int'(sleep_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule